// File: doc/BRIEF.md
# Late-Write Synchronous SRAM

This block is a single-port synchronous SRAM. Address, select and write enable are taken on the rising clock edge. Read data leaves on a shared bidirectional data bus, and write data enters on the same bus. A write presents its address in one cycle and its data on the next rising edge. The word does not go straight into the array. It waits in a one-deep buffer and moves into the core only when the next write begins. Reads that hit the buffered address return the buffered word, so the buffer cannot be seen from outside.

Two static mode pins pick how read data reaches the bus:
- **Pipelined:** two register stages.
- **Single-stage:** one register stage.
- **Hold-at-high:** one stage followed by a hold element that is transparent while the clock is low and holds while it is high.

In the single-stage and hold-at-high modes, a write turns the bus drivers off right after its own edge, so a read can follow a write and a write can follow a read with no idle cycle between them. Output enable and sleep act at once, without waiting for the clock. While sleep is high, accesses are ignored and the bus is released.

Top module: `lw_sram`

## Requirements
- R1: Select, write enable and address count only at the rising clock edge. Changes between edges have no effect.
- R2: The word written is the value on the data bus at the rising edge one cycle after the edge that took the write address.
- R3: A write waits in a one-deep buffer and is copied into the array when the next write starts. A word read back later, after other writes have passed through the buffer, equals the data written.
- R4: A read whose address matches the buffered write returns that write's data. This holds both when the data is still arriving on the bus at the read edge and when it has already been buffered.
- R5: The mode pins decode as follows: 2'b00 gives pipelined, 2'b01 gives single-stage, 2'b10 gives hold-at-high, and the unused code 2'b11 behaves as pipelined.
- R6: In single-stage mode, data for a read taken at edge n is on the bus from edge n until edge n+1. With no read at an edge, the bus is released after that edge.
- R7: In pipelined mode, data for a read taken at edge n is on the bus from edge n+1 until edge n+2.
- R8: In hold-at-high mode, read data taken at edge n appears once the clock falls after edge n. It is held through the high phase that follows edge n+1.
- R9: In single-stage and hold-at-high modes, a write taken at an edge releases the bus directly after that edge, including in the high phase.
- R10: While output enable is low, the bus is released at once. Raising it again restores the pending read data.
- R11: While sleep is high, the bus is released at once and reads or writes presented at an edge are ignored. The array keeps its contents.
- R12: After reset the bus is released, and the word width is 18 bits by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all captures on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr | input | AW | Word address |
| sel | input | 1 | Access select, active high |
| wen | input | 1 | Write enable (1 = write, 0 = read) when selected |
| oe | input | 1 | Output enable, active high, asynchronous |
| sleep | input | 1 | Power-down, active high, asynchronous |
| mode_pins | input | 2 | Read output mode, static after reset |
| dq | inout | DW | Shared read/write data bus |

## Verification
Every mode is run through the following patterns, with random reads, writes and idles mixed in:
- **Back-to-back writes over the whole array, then read back.** This separates a working commit of the buffer from a lost or misplaced word.
- **Write, then an immediate read of the same address.** This tests bypass from the bus.
- **Write, idle, then read of the same address.** This tests bypass from the buffer.
- **Two writes, then a read of the first address.** This tests the read from the array after a commit.
- **Read followed by write (single-stage and hold-at-high only).** The bus is sampled in both clock phases. This separates a hold stage that is cleared by the write from one that keeps driving into the write data.

Asynchronous toggles of output enable and sleep in mid-cycle, and writes presented while asleep, show that those inputs act without the clock and that ignored accesses leave the array unchanged.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

  typedef enum logic [1:0] {
    OUT_REGREG = 2'b00,
    OUT_FLOW   = 2'b01,
    OUT_LATCH  = 2'b10
  } out_mode_e;

  // Unused code 2'b11 falls back to the two-stage registered mode.
  function automatic out_mode_e decode_mode(input logic [1:0] pins);
    case (pins)
      2'b01:   return OUT_FLOW;
      2'b10:   return OUT_LATCH;
      default: return OUT_REGREG;
    endcase
  endfunction

endpackage

// File: rtl/lw_sram_core.sv
module lw_sram_core #(
  parameter int DW = 18,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/lw_sram_wbuf.sv
module lw_sram_wbuf #(
  parameter int DW = 18,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_start,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] data_in,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] core_rdata,
  output logic          commit_en,
  output logic [AW-1:0] commit_addr,
  output logic [DW-1:0] commit_data,
  output logic [DW-1:0] rd_word
);

  logic          buf_valid;
  logic          wr_pend;
  logic [AW-1:0] buf_addr;
  logic [DW-1:0] buf_data;
  logic          buf_hit;
  logic [DW-1:0] buf_word;

  function automatic logic addr_match(input logic v, input logic [AW-1:0] a,
                                      input logic [AW-1:0] b);
    return v && (a == b);
  endfunction

  // While the data phase is in progress the newest word is still on the bus.
  assign buf_word    = wr_pend ? data_in : buf_data;
  assign buf_hit     = addr_match(buf_valid, rd_addr, buf_addr);
  assign rd_word     = buf_hit ? buf_word : core_rdata;
  assign commit_en   = wr_start && buf_valid;
  assign commit_addr = buf_addr;
  assign commit_data = buf_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_valid <= 1'b0;
      wr_pend   <= 1'b0;
      buf_addr  <= '0;
      buf_data  <= '0;
    end else begin
      wr_pend <= wr_start;
      if (wr_start) begin
        buf_valid <= 1'b1;
        buf_addr  <= wr_addr;
      end
      if (wr_pend) buf_data <= data_in;
    end
  end

  assert_buf_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> (buf_addr == $past(wr_addr)));

  assert_data_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pend |=> (buf_data == $past(data_in)));

  assert_commit_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> buf_valid);

endmodule

// File: rtl/lw_sram_outstage.sv
module lw_sram_outstage
  import lw_sram_pkg::*;
#(
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  out_mode_e     mode,
  input  logic          rd_start,
  input  logic          wr_start,
  input  logic [DW-1:0] rd_word,
  input  logic          oe,
  input  logic          sleep,
  output logic          rd_live,
  output logic          drive,
  output logic [DW-1:0] dout
);

  logic          rd_v1, rd_v2, wr_v1, hold_en;
  logic [DW-1:0] rd_q, rr_q, hold_q;
  logic          mode_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_v1   <= 1'b0;
      rd_v2   <= 1'b0;
      wr_v1   <= 1'b0;
      hold_en <= 1'b0;
      rd_q    <= '0;
      rr_q    <= '0;
      hold_q  <= '0;
    end else begin
      rd_v1   <= rd_start;
      rd_v2   <= rd_v1;
      wr_v1   <= wr_start;
      hold_en <= rd_v1;
      hold_q  <= rd_q;
      rr_q    <= rd_q;
      if (rd_start) rd_q <= rd_word;
    end
  end

  // Hold-at-high: follow stage one while clk is low, keep the pre-edge value while high.
  always_comb begin
    case (mode)
      OUT_FLOW: begin
        mode_en = rd_v1;
        dout    = rd_q;
      end
      OUT_LATCH: begin
        mode_en = (clk ? hold_en : rd_v1) && !wr_v1;
        dout    = clk ? hold_q : rd_q;
      end
      default: begin
        mode_en = rd_v2;
        dout    = rr_q;
      end
    endcase
  end

  assign drive   = mode_en && oe && !sleep;
  assign rd_live = rd_v1;

  assert_rr_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |-> ##2 rd_v2);

  assert_wr_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_start && mode != OUT_REGREG) |=> !rd_v1);

endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int DW = 18,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          sel,
  input  logic          wen,
  input  logic          oe,
  input  logic          sleep,
  input  logic [1:0]    mode_pins,
  inout  wire  [DW-1:0] dq
);

  out_mode_e     mode;
  logic          rd_start, wr_start;
  logic [DW-1:0] dq_in, core_rdata, rd_word, commit_data, dout;
  logic [AW-1:0] commit_addr;
  logic          commit_en, drive, rd_live;

  assign mode     = decode_mode(mode_pins);
  assign rd_start = sel && !wen && !sleep;
  assign wr_start = sel && wen && !sleep;
  assign dq_in    = dq;
  assign dq       = drive ? dout : {DW{1'bz}};

  lw_sram_core #(.DW(DW), .AW(AW)) core_i (
    .clk   (clk),
    .we    (commit_en),
    .waddr (commit_addr),
    .wdata (commit_data),
    .raddr (addr),
    .rdata (core_rdata)
  );

  lw_sram_wbuf #(.DW(DW), .AW(AW)) wbuf_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_start    (wr_start),
    .wr_addr     (addr),
    .data_in     (dq_in),
    .rd_addr     (addr),
    .core_rdata  (core_rdata),
    .commit_en   (commit_en),
    .commit_addr (commit_addr),
    .commit_data (commit_data),
    .rd_word     (rd_word)
  );

  lw_sram_outstage #(.DW(DW)) out_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .rd_start (rd_start),
    .wr_start (wr_start),
    .rd_word  (rd_word),
    .oe       (oe),
    .sleep    (sleep),
    .rd_live  (rd_live),
    .drive    (drive),
    .dout     (dout)
  );

  assert_sleep_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !rd_live);

  assert_no_read_on_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wen) |=> !rd_live);

endmodule

// File: tb/lw_sram_tb_top.sv
`timescale 1ns/100ps
module lw_sram_tb_top;
  localparam int DW = 18;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;
  localparam logic [DW-1:0] RELEASED = {DW{1'b1}};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          sel = 1'b0, wen = 1'b0, oe = 1'b1, sleep = 1'b0;
  logic [1:0]    mode_pins = 2'b00;
  logic          tb_drive = 1'b0;
  logic [DW-1:0] tb_dq = '0;
  wire  [DW-1:0] dq;

  pullup pu[DW-1:0] (dq);
  assign dq = tb_drive ? tb_dq : {DW{1'bz}};

  lw_sram #(.DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel(sel), .wen(wen),
    .oe(oe), .sleep(sleep), .mode_pins(mode_pins), .dq(dq)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [DW-1:0] ref_mem [DEPTH];
  bit            pend_w, rd_prev, slp_req;
  logic [AW-1:0] pend_a;
  logic [DW-1:0] pend_d, exp_prev;
  int            kind;   // 0 pipelined, 1 single-stage, 2 hold-at-high
  string         def_tag;

  function automatic int mode_kind(input logic [1:0] m);
    if (m == 2'b01) return 1;
    if (m == 2'b10) return 2;
    return 0;
  endfunction

  function automatic logic [DW-1:0] rand_word();
    return DW'($urandom % (1 << (DW - 1)));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic chk_data(input string tag, input logic [DW-1:0] exp);
    chk(dq === exp, tag, dq, exp);
  endtask

  task automatic chk_rel(input string tag);
    chk(dq === RELEASED, tag, dq, RELEASED);
  endtask

  task automatic do_reset(input logic [1:0] m);
    rst_n = 1'b0; mode_pins = m; sel = 0; wen = 0; oe = 1; sleep = 0;
    tb_drive = 0; pend_w = 0; rd_prev = 0; slp_req = 0;
    kind = mode_kind(m);
    def_tag = (m == 2'b11) ? "R5" : (kind == 1) ? "R6" : (kind == 2) ? "R8" : "R7";
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #5 chk_rel("R12");
  endtask

  // Called in the low phase; one rising edge per call; returns at edge + 6 ns.
  task automatic tick(input bit rd, input bit wr, input logic [AW-1:0] a,
                      input string tag);
    bit eff_rd, eff_wr;
    logic [DW-1:0] exp_now;
    string t;
    sel = rd | wr; wen = wr; addr = a; sleep = slp_req;
    if (pend_w) begin tb_drive = 1; tb_dq = pend_d; end
    @(posedge clk);
    if (pend_w) ref_mem[pend_a] = pend_d;
    eff_rd = rd && !slp_req;
    eff_wr = wr && !slp_req;
    exp_now = ref_mem[a];
    pend_w = eff_wr; pend_a = a; pend_d = rand_word();
    #1;
    tb_drive = 0; sleep = 0;
    addr = AW'($urandom); sel = 1'($urandom); wen = 1'($urandom);  // R1: after-edge noise
    #1;
    if (kind == 2 && rd_prev) begin
      if (eff_wr) chk_rel("R9");
      else        chk_data("R8", exp_prev);
    end
    #4;
    t = (tag != "") ? tag : def_tag;
    if (kind == 0) begin
      if (rd_prev) chk_data(t, exp_prev);
      else         chk_rel(t);
    end else begin
      if (eff_rd)      chk_data(t, exp_now);
      else if (eff_wr) chk_rel("R9");
      else             chk_rel(t);
    end
    rd_prev = eff_rd; exp_prev = exp_now;
    sel = 0; wen = 0;
  endtask

  task automatic idle();
    tick(0, 0, '0, "");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int m = 0; m < 4; m++) begin
      do_reset(2'(m));
      // R2/R3: back-to-back writes over the whole array, then read back
      for (int a = 0; a < DEPTH; a++) tick(0, 1, AW'(a), "R3");
      idle();
      for (int a = 0; a < DEPTH; a++) tick(1, 0, AW'(a), "R2");
      idle();
      // R4: read at the data edge (bypass from the bus)
      tick(0, 1, 6'd5, ""); tick(1, 0, 6'd5, "R4"); idle();
      // R4: read from the buffer after an idle
      tick(0, 1, 6'd9, ""); idle(); tick(1, 0, 6'd9, "R4"); idle();
      // R3: first write committed by a second write
      tick(0, 1, 6'd10, ""); tick(0, 1, 6'd11, ""); idle();
      tick(1, 0, 6'd10, "R3"); tick(1, 0, 6'd11, "R3"); idle();
      // R1: inputs scrambled after the edge do not matter
      tick(1, 0, 6'd20, "R1"); idle();
      // R11: accesses during sleep are ignored
      slp_req = 1; tick(0, 1, 6'd30, "R11"); slp_req = 0; idle();
      tick(1, 0, 6'd30, "R11"); idle();
      slp_req = 1; tick(1, 0, 6'd31, "R11"); slp_req = 0; idle(); idle();
      // R9: write right after read (not for pipelined mode)
      if (kind != 0) begin
        tick(1, 0, 6'd1, ""); tick(0, 1, 6'd2, "R9"); idle();
        tick(1, 0, 6'd2, "R9"); idle();
      end
      // R10/R11: asynchronous release in single-stage mode
      if (kind == 1) begin
        tick(1, 0, 6'd40, "R6");
        oe = 0;    #0.4 chk_rel("R10");
        oe = 1;    #0.4 chk_data("R10", ref_mem[40]);
        sleep = 1; #0.4 chk_rel("R11");
        sleep = 0; #0.4 chk_data("R11", ref_mem[40]);
        idle();
      end
      // Random mix
      for (int i = 0; i < 250; i++) begin
        int op;
        op = int'($urandom % 3);
        if (kind == 0 && rd_prev && op == 2) op = 0;
        tick(op == 1, op == 2, AW'($urandom), "");
      end
      idle(); idle();
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule